// File: doc/BRIEF.md
# Digit-Serial Decimal Floating-Point Multiplier

This block multiplies two decimal floating-point numbers whose mantissas are unsigned BCD integers held one digit per location in small operand memories, each paired with a signed binary power-of-ten exponent. A value is `M * 10^E`, with digit position 0 as the least significant digit of `M`. Software fills both operands through a digit-wide load port, picks a precision of N digits, and pulses `start`. The block then walks the schoolbook product one digit pair per cycle. A 256-location digit-pair table gives each two-digit product. A 4-bit decimal adder folds that product into a 2N-digit accumulator, and the carry moves up one digit per cycle.

After the multiply, the block normalizes the result without moving any stored digit. A pointer starts at the top of the accumulator and steps down past leading zero digits. The read port and the result exponent are both formed relative to that pointer. The result is the N accumulator digits ending at the pointer, truncated below. The exponent is the sum of the operand exponents plus the pointer offset. The run length depends only on N, so the host can count cycles or wait for the single-cycle `done` pulse.

Top module: `bcd_fpmul`

## Requirements
- R1: With P the exact product of the two N-digit mantissas and k the position of its highest nonzero digit, result digit j (j = 0..N-1) equals digit k-N+1+j of P, or 0 where that position is below 0; lower product digits are dropped.
- R2: `prec` sampled at the accepted start selects N; values 1..14 are used as given, and 0 or 15 select 14; operand digits at positions N and above take no part in the product.
- R3: For a nonzero product, `res_exp` equals ea + eb + k - (N-1) as a 10-bit two's complement value, where ea and eb are the 8-bit two's complement operand exponents.
- R4: If either mantissa has all N digits zero, every result digit reads 0 and `res_exp` reads 0.
- R5: `done` is high for exactly one cycle, N*N + 3*N - 1 clock edges after the edge that accepts `start`; `busy` is high on every cycle in between and low while `done` is high.
- R6: An operand digit code from 10 to 15 at a position below N sets `err`, which is visible at `done`; an accepted start clears `err`, and the table treats such a digit as producing 00.
- R7: While `busy` is high, `start`, digit loads and exponent loads are ignored; the running product and later runs use the operands as they stood at the accepted start.
- R8: `rd_digit` returns result digit `rd_addr`, with 0 the least significant; any `rd_addr` of N or more reads 0.
- R9: After reset, `busy`, `done` and `err` are low.
- R10: A digit load writes `ld_digit` to position `ld_addr` of operand B when `ld_opb` is 1, else of operand A; an exponent load writes `ld_exp` the same way; load addresses of 14 or more are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_en | input | 1 | Write one operand digit |
| ld_opb | input | 1 | Operand select for loads: 0 = A, 1 = B |
| ld_addr | input | 4 | Digit position to write, 0 = least significant |
| ld_digit | input | 4 | BCD digit to write |
| ld_exp_en | input | 1 | Write the selected operand's exponent |
| ld_exp | input | 8 | Exponent, two's complement |
| prec | input | 4 | Requested mantissa precision N |
| start | input | 1 | Begin a multiply when not busy |
| busy | output | 1 | Multiply or normalization in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Non-decimal operand digit seen in the last run |
| res_exp | output | 10 | Result exponent, two's complement |
| rd_addr | input | 4 | Result digit position to read |
| rd_digit | output | 4 | Result digit at `rd_addr` |

## Verification
The bench builds the block with its default parameters: up to 14 digits and 8-bit exponents. With these values, a 4-bit precision input can ask for both 0 and 15, so the clamp to 14 digits is exercised alongside the single-digit and full-width extremes. At 14 digits the all-nines product reaches the deepest carry chain and the longest run of 237 cycles. Tiny products at full precision drive the pointer almost to the bottom of the accumulator and produce strongly negative exponent adjustments. Load addresses 14 and 15 fit the address port but lie past the operand memory, so their rejection can be checked.

// File: rtl/bcd_fpmul_pkg.sv
package bcd_fpmul_pkg;

    // One packed BCD digit.
    typedef logic [3:0] digit_t;

    // Sequencer phases.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_MUL  = 2'd1,
        PH_NORM = 2'd2,
        PH_FIN  = 2'd3
    } phase_t;

    localparam int unsigned DEF_MAX_DIGITS = 14;
    localparam int unsigned DEF_EXP_W      = 8;

endpackage

// File: rtl/bcd_digit_table.sv
module bcd_digit_table
    import bcd_fpmul_pkg::*;
(
    input  digit_t a_i,
    input  digit_t b_i,
    output digit_t hi_o,
    output digit_t lo_o,
    output logic   bad_o
);

    localparam int unsigned ENTRIES = 256;

    logic [7:0] rom [ENTRIES];

    // Each location holds the two-digit BCD product of its address halves.
    // Locations with a non-decimal half hold 00.
    for (genvar k = 0; k < ENTRIES; k++) begin : g_entry
        localparam int unsigned X = k / 16;
        localparam int unsigned Y = k % 16;
        localparam int unsigned P = X * Y;
        if (X < 10 && Y < 10) begin : g_dec
            assign rom[k] = {4'(P / 10), 4'(P % 10)};
        end else begin : g_inv
            assign rom[k] = 8'h00;
        end
    end

    assign {hi_o, lo_o} = rom[{a_i, b_i}];
    assign bad_o        = (a_i > 4'd9) || (b_i > 4'd9);

endmodule

// File: rtl/bcd_mac_digit.sv
module bcd_mac_digit
    import bcd_fpmul_pkg::*;
(
    input  digit_t acc_i,
    input  digit_t lo_i,
    input  digit_t hi_i,
    input  digit_t cin_i,
    output digit_t sum_o,
    output digit_t cout_o
);

    logic [4:0] total;
    logic [1:0] up;

    // acc + lo + cin is at most 27. acc + a*b + cin is at most 99,
    // so the outgoing carry is still one decimal digit.
    always_comb begin
        total = {1'b0, acc_i} + {1'b0, lo_i} + {1'b0, cin_i};
        if (total >= 5'd20) begin
            sum_o = 4'(total - 5'd20);
            up    = 2'd2;
        end else if (total >= 5'd10) begin
            sum_o = 4'(total - 5'd10);
            up    = 2'd1;
        end else begin
            sum_o = total[3:0];
            up    = 2'd0;
        end
        cout_o = hi_i + {2'b00, up};
    end

endmodule

// File: rtl/bcd_result_view.sv
module bcd_result_view
    import bcd_fpmul_pkg::*;
#(
    parameter int unsigned ACC_D = 28,
    parameter int unsigned PTR_W = 5,
    parameter int unsigned N_W   = 4,
    parameter int unsigned IDX_W = 4
) (
    input  logic [ACC_D-1:0][3:0] acc_i,
    input  logic [PTR_W-1:0]      ptr_i,
    input  logic [N_W-1:0]        n_i,
    input  logic                  zero_i,
    input  logic [IDX_W-1:0]      rd_addr_i,
    output digit_t                digit_o
);

    localparam int unsigned SW = PTR_W + IDX_W + 2;

    logic [SW-1:0] pos;
    logic          live;

    // Position in the accumulator = ptr - (N-1) + rd_addr.
    always_comb begin
        pos  = SW'(ptr_i) + SW'(rd_addr_i) + SW'(1) - SW'(n_i);
        live = !zero_i && (SW'(rd_addr_i) < SW'(n_i)) && !pos[SW-1];
        digit_o = '0;
        for (int k = 0; k < ACC_D; k++) begin
            if (live && pos == SW'(k)) begin
                digit_o = acc_i[k];
            end
        end
    end

endmodule

// File: rtl/bcd_fpmul.sv
module bcd_fpmul
    import bcd_fpmul_pkg::*;
#(
    parameter int unsigned MAXD  = DEF_MAX_DIGITS,
    parameter int unsigned EXP_W = DEF_EXP_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ld_en,
    input  logic                        ld_opb,
    input  logic [$clog2(MAXD)-1:0]     ld_addr,
    input  logic [3:0]                  ld_digit,
    input  logic                        ld_exp_en,
    input  logic [EXP_W-1:0]            ld_exp,
    input  logic [$clog2(MAXD+1)-1:0]   prec,
    input  logic                        start,
    output logic                        busy,
    output logic                        done,
    output logic                        err,
    output logic [EXP_W+1:0]            res_exp,
    input  logic [$clog2(MAXD)-1:0]     rd_addr,
    output logic [3:0]                  rd_digit
);

    localparam int unsigned IDX_W = $clog2(MAXD);
    localparam int unsigned N_W   = $clog2(MAXD + 1);
    localparam int unsigned ACC_D = 2 * MAXD;
    localparam int unsigned PTR_W = $clog2(ACC_D);
    localparam int unsigned REX_W = EXP_W + 2;

    typedef struct packed {
        phase_t                   phase;
        logic [N_W-1:0]           n;
        logic [N_W-1:0]           row;
        logic [N_W-1:0]           col;
        logic [PTR_W-1:0]         ptr;
        logic [PTR_W-1:0]         ncnt;
        digit_t                   carry;
        logic                     a_nz;
        logic                     b_nz;
        logic                     err;
        logic [EXP_W-1:0]         ea;
        logic [EXP_W-1:0]         eb;
        logic [MAXD-1:0][3:0]     opa;
        logic [MAXD-1:0][3:0]     opb;
        logic [ACC_D-1:0][3:0]    acc;
    } st_t;

    st_t q, d;

    digit_t           sel_a, sel_b, acc_cur, ptr_dig;
    digit_t           tab_hi, tab_lo, mac_sum, mac_cout;
    digit_t           prod_hi, prod_lo;
    logic             tab_bad;
    logic             in_row, zero;
    logic [PTR_W-1:0] acc_idx;
    logic [PTR_W-1:0] two_n;
    logic [N_W-1:0]   n_eff;

    // ---------------- operand and accumulator selection ----------------
    always_comb begin
        sel_a = '0;
        sel_b = '0;
        for (int k = 0; k < MAXD; k++) begin
            if (q.col == N_W'(k)) sel_a = q.opa[k];
            if (q.row == N_W'(k)) sel_b = q.opb[k];
        end
    end

    assign acc_idx = PTR_W'(q.row) + PTR_W'(q.col);
    assign two_n   = PTR_W'({q.n, 1'b0});
    assign in_row  = (q.col != q.n);
    assign zero    = !(q.a_nz && q.b_nz);

    always_comb begin
        acc_cur = '0;
        ptr_dig = '0;
        for (int k = 0; k < ACC_D; k++) begin
            if (acc_idx == PTR_W'(k)) acc_cur = q.acc[k];
            if (q.ptr == PTR_W'(k))   ptr_dig = q.acc[k];
        end
    end

    // ---------------- datapath: table and digit adder ----------------
    bcd_digit_table i_table (
        .a_i   (sel_a),
        .b_i   (sel_b),
        .hi_o  (tab_hi),
        .lo_o  (tab_lo),
        .bad_o (tab_bad)
    );

    // At the end of a row only the pending carry is written.
    assign prod_hi = in_row ? tab_hi : '0;
    assign prod_lo = in_row ? tab_lo : '0;

    bcd_mac_digit i_mac (
        .acc_i  (acc_cur),
        .lo_i   (prod_lo),
        .hi_i   (prod_hi),
        .cin_i  (q.carry),
        .sum_o  (mac_sum),
        .cout_o (mac_cout)
    );

    assign n_eff = (prec == '0 || prec > N_W'(MAXD)) ? N_W'(MAXD) : prec;

    // ---------------- sequencer next state ----------------
    always_comb begin
        d = q;
        unique case (q.phase)
            PH_IDLE, PH_FIN: begin
                if (ld_en) begin
                    for (int k = 0; k < MAXD; k++) begin
                        if (ld_addr == IDX_W'(k)) begin
                            if (ld_opb) d.opb[k] = ld_digit;
                            else        d.opa[k] = ld_digit;
                        end
                    end
                end
                if (ld_exp_en) begin
                    if (ld_opb) d.eb = ld_exp;
                    else        d.ea = ld_exp;
                end
                if (start) begin
                    d.phase = PH_MUL;
                    d.n     = n_eff;
                    d.row   = '0;
                    d.col   = '0;
                    d.carry = '0;
                    d.err   = 1'b0;
                    d.a_nz  = 1'b0;
                    d.b_nz  = 1'b0;
                    d.acc   = '0;
                end else begin
                    d.phase = PH_IDLE;
                end
            end
            PH_MUL: begin
                for (int k = 0; k < ACC_D; k++) begin
                    if (acc_idx == PTR_W'(k)) d.acc[k] = mac_sum;
                end
                if (in_row) begin
                    d.carry = mac_cout;
                    d.err   = q.err | tab_bad;
                    if (q.row == '0 && sel_a != '0) d.a_nz = 1'b1;
                    if (q.col == '0 && sel_b != '0) d.b_nz = 1'b1;
                    d.col   = q.col + N_W'(1);
                end else begin
                    d.carry = '0;
                    d.col   = '0;
                    if (q.row == q.n - N_W'(1)) begin
                        d.phase = PH_NORM;
                        d.ptr   = two_n - PTR_W'(1);
                        d.ncnt  = '0;
                    end else begin
                        d.row = q.row + N_W'(1);
                    end
                end
            end
            PH_NORM: begin
                if (!zero && ptr_dig == '0 && q.ptr != '0) begin
                    d.ptr = q.ptr - PTR_W'(1);
                end
                if (q.ncnt == two_n - PTR_W'(2)) begin
                    d.phase = PH_FIN;
                end else begin
                    d.ncnt = q.ncnt + PTR_W'(1);
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // ---------------- outputs ----------------
    assign busy = (q.phase == PH_MUL) || (q.phase == PH_NORM);
    assign done = (q.phase == PH_FIN);
    assign err  = q.err;

    always_comb begin
        if (zero) begin
            res_exp = '0;
        end else begin
            res_exp = {{(REX_W-EXP_W){q.ea[EXP_W-1]}}, q.ea}
                    + {{(REX_W-EXP_W){q.eb[EXP_W-1]}}, q.eb}
                    + REX_W'(q.ptr) + REX_W'(1) - REX_W'(q.n);
        end
    end

    bcd_result_view #(
        .ACC_D (ACC_D),
        .PTR_W (PTR_W),
        .N_W   (N_W),
        .IDX_W (IDX_W)
    ) i_view (
        .acc_i     (q.acc),
        .ptr_i     (q.ptr),
        .n_i       (q.n),
        .zero_i    (zero),
        .rd_addr_i (rd_addr),
        .digit_o   (rd_digit)
    );

endmodule

// File: rtl/bcd_fpmul_chk.sv
module bcd_fpmul_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic [3:0] rd_digit
);

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_done_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    assert_busy_ends_in_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    assert_start_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_err_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> !err);

    assert_digit_decimal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_digit <= 4'd9);

endmodule

bind bcd_fpmul bcd_fpmul_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .rd_digit (rd_digit)
);

// File: tb/test_bcd_fpmul.sv
module test_bcd_fpmul;

    localparam int MAXD  = 14;
    localparam int EXP_W = 8;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ld_en, ld_opb, ld_exp_en, start;
    logic [3:0] ld_addr, ld_digit, prec, rd_addr, rd_digit;
    logic [7:0] ld_exp;
    logic       busy, done, err;
    logic [9:0] res_exp;

    int checks = 0;
    int errors = 0;

    bcd_fpmul #(.MAXD(MAXD), .EXP_W(EXP_W)) i_bcd_fpmul (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_opb(ld_opb),
        .ld_addr(ld_addr), .ld_digit(ld_digit), .ld_exp_en(ld_exp_en),
        .ld_exp(ld_exp), .prec(prec), .start(start), .busy(busy),
        .done(done), .err(err), .res_exp(res_exp), .rd_addr(rd_addr),
        .rd_digit(rd_digit)
    );

    always #2 clk = ~clk;

    typedef struct packed {
        logic [3:0]  p;
        logic [55:0] a;
        logic [55:0] b;
        logic [7:0]  ea;
        logic [7:0]  eb;
        logic [9:0]  rexp;
        logic [55:0] res;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{4'd4,  56'h77777777771234, 56'h5,              8'h00, 8'h00, 10'h000, 56'h6170},
        '{4'd4,  56'h9999,           56'h9999,           8'h02, 8'hFD, 10'h003, 56'h9998},
        '{4'd3,  56'h1,              56'h1,              8'h05, 8'h05, 10'h008, 56'h100},
        '{4'd2,  56'h25,             56'h4,              8'hFF, 8'h00, 10'h000, 56'h10},
        '{4'd1,  56'h7,              56'h8,              8'h00, 8'h00, 10'h001, 56'h5},
        '{4'd5,  56'h12345,          56'h67890,          8'h00, 8'h00, 10'h004, 56'h83810},
        '{4'd4,  56'h0,              56'h1234,           8'h07, 8'h03, 10'h000, 56'h0},
        '{4'd14, 56'h99999999999999, 56'h99999999999999, 8'h00, 8'h00, 10'h00E, 56'h99999999999998},
        '{4'd0,  56'h2,              56'h5,              8'h00, 8'h00, 10'h3F4, 56'h10000000000000},
        '{4'd15, 56'h12,             56'h12,             8'h00, 8'h00, 10'h3F5, 56'h14400000000000}
    };

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int lat_of(input logic [3:0] p);
        int n;
        n = (p == 0 || p > MAXD) ? MAXD : int'(p);
        return n * n + 3 * n - 1;
    endfunction

    task automatic load_op(input bit sel, input logic [55:0] v, input logic [7:0] e);
        for (int k = 0; k < MAXD; k++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_opb = sel; ld_addr = 4'(k); ld_digit = v[4*k +: 4];
        end
        @(negedge clk);
        ld_en = 1'b0; ld_exp_en = 1'b1; ld_opb = sel; ld_exp = e;
        @(negedge clk);
        ld_exp_en = 1'b0;
    endtask

    task automatic run(input logic [3:0] p, input bit disturb,
                       output int cyc, output bit pulse_ok, output bit busy_ok,
                       output logic [55:0] res, output logic [9:0] rexp, output logic er);
        @(negedge clk);
        prec = p; start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        cyc = 0; busy_ok = 1'b1;
        while (cyc < 1000) begin
            @(posedge clk);
            cyc++;
            #1;
            if (disturb && cyc == 5) begin
                start = 1'b1; ld_en = 1'b1; ld_opb = 1'b0; ld_addr = 4'd0;
                ld_digit = 4'd9; ld_exp_en = 1'b1; ld_exp = 8'd50;
            end else begin
                start = 1'b0; ld_en = 1'b0; ld_exp_en = 1'b0;
            end
            if (done) break;
            if (!busy) busy_ok = 1'b0;
        end
        if (busy && done) busy_ok = 1'b0;
        er = err; rexp = res_exp;
        @(posedge clk);
        #1 pulse_ok = !done;
        start = 1'b0; ld_en = 1'b0; ld_exp_en = 1'b0;
        res = '0;
        for (int k = 0; k < MAXD; k++) begin
            rd_addr = 4'(k);
            #1 res[4*k +: 4] = rd_digit;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R5 actual %0d expected %0d", 150000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cyc;
        bit pulse_ok, busy_ok;
        logic [55:0] res;
        logic [9:0] rexp;
        logic er;

        rst_n = 1'b0; ld_en = 1'b0; ld_opb = 1'b0; ld_exp_en = 1'b0; start = 1'b0;
        ld_addr = '0; ld_digit = '0; ld_exp = '0; prec = 4'd4; rd_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R9: idle outputs after reset
        check(!busy && !done && !err, "R9 reset state", {busy, done, err}, 0);

        // Vector table: R1 R2 R3 R4 R5 R8 R10
        for (int i = 0; i < NV; i++) begin
            load_op(1'b0, VECS[i].a, VECS[i].ea);
            load_op(1'b1, VECS[i].b, VECS[i].eb);
            run(VECS[i].p, 1'b0, cyc, pulse_ok, busy_ok, res, rexp, er);
            check(cyc == lat_of(VECS[i].p), $sformatf("R5 R2 latency vec %0d", i), cyc, lat_of(VECS[i].p));
            check(pulse_ok && busy_ok, $sformatf("R5 done pulse and busy vec %0d", i), {pulse_ok, busy_ok}, 3);
            check(res == VECS[i].res, $sformatf("%s R8 digits vec %0d", (i == 6) ? "R4" : "R1", i), res, VECS[i].res);
            check(rexp == VECS[i].rexp, $sformatf("%s exponent vec %0d", (i == 6) ? "R4" : "R3", i), rexp, VECS[i].rexp);
            check(er == 1'b0, $sformatf("R6 no error vec %0d", i), er, 0);
        end

        // R6: non-decimal digit below N flags err; next valid run clears it
        load_op(1'b0, 56'hC2, 8'h00);
        load_op(1'b1, 56'h3, 8'h00);
        run(4'd2, 1'b0, cyc, pulse_ok, busy_ok, res, rexp, er);
        check(er == 1'b1, "R6 invalid digit flags err", er, 1);
        load_op(1'b0, 56'h12, 8'h00);
        run(4'd2, 1'b0, cyc, pulse_ok, busy_ok, res, rexp, er);
        check(er == 1'b0, "R6 err cleared by start", er, 0);
        check(res == 56'h36, "R1 product after error run", res, 56'h36);

        // R7: start and loads while busy are ignored
        load_op(1'b0, 56'h12345, 8'h00);
        load_op(1'b1, 56'h67890, 8'h00);
        run(4'd5, 1'b1, cyc, pulse_ok, busy_ok, res, rexp, er);
        check(cyc == 39, "R7 latency with start while busy", cyc, 39);
        check(pulse_ok, "R7 single done pulse", pulse_ok, 1);
        check(res == 56'h83810, "R7 digits unaffected by busy loads", res, 56'h83810);
        check(rexp == 10'h004, "R7 exponent unaffected by busy load", rexp, 4);
        run(4'd5, 1'b0, cyc, pulse_ok, busy_ok, res, rexp, er);
        check(res == 56'h83810 && rexp == 10'h004, "R7 operands kept after busy loads", res, 56'h83810);

        // R10: load addresses 14 and 15 are ignored
        @(negedge clk);
        ld_en = 1'b1; ld_opb = 1'b0; ld_addr = 4'd14; ld_digit = 4'd9;
        @(negedge clk);
        ld_addr = 4'd15;
        @(negedge clk);
        ld_en = 1'b0;
        run(4'd14, 1'b0, cyc, pulse_ok, busy_ok, res, rexp, er);
        check(res == 56'h83810205000000, "R10 out-of-range load ignored", res, 56'h83810205000000);
        check(rexp == 10'h3FB, "R3 exponent at full precision", rexp, 10'h3FB);

        // R8: addresses at or past N read zero
        @(negedge clk);
        rd_addr = 4'd14;
        #1 check(rd_digit == 4'd0, "R8 address 14 reads zero", rd_digit, 0);
        rd_addr = 4'd15;
        #1 check(rd_digit == 4'd0, "R8 address 15 reads zero", rd_digit, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule